// File: doc/BRIEF.md
# SDRAM Burst Sequencer with Periodic Refresh

This block sits between a host port and an SDRAM device. It turns one accepted host transfer into the full command sequence for a closed-page burst: it opens the row, waits out the row-to-column delay, issues one read or write command per port-width beat with its own column address, pads with no-operation cycles until the minimum row-active time is met, closes every bank, and then holds off new work for the programmed precharge recovery.

A programmable down-counter schedules auto-refresh. When it expires, a single pending-refresh flag is raised. The flag is served only when the sequencer is idle, that is after a burst has closed its row and served its recovery time. Serving it takes a close-all, a recovery wait, the refresh command and a refresh recovery wait. Host requests use a valid/ready handshake and are refused while a refresh is pending or running.

Top module: `sdram_burst_seq`

## Requirements
- R1: Command pins {csN,rasN,casN,weN} use NOP=0111, ACTIVATE=0011, READ=0101, WRITE=0100, CLOSE-ALL=0010, REFRESH=0001. A burst always runs ACTIVATE, NOPs, beats, NOPs, CLOSE-ALL, NOPs. The beat command is WRITE when reqWrite was set at acceptance, READ otherwise.
- R2: Counting ACTIVATE as cycle 0, the first beat appears in cycle max(casLat,1). With casLat of 1 the beat follows ACTIVATE directly.
- R3: The number of beats is max(1, transfer bytes / port bytes). reqSize 0,1,2,3 means 1, 2, 4, 16 bytes. reqPort 0 means an 8-bit port, 1 a 16-bit port, and 2 or 3 a 32-bit port.
- R4: CLOSE-ALL appears in cycle max(last beat + 1, tRas).
- R5: After CLOSE-ALL, tRp NOP cycles follow. In the cycle after them hostBusy is low and hostDone is high for exactly one cycle. hostDone is never high while hostBusy is high.
- R6: ACTIVATE drives the row on sdAddr. Beat i drives reqCol+i. CLOSE-ALL drives sdAddr with bit 10 set and all other bits clear.
- R7: While refEn is low the counter holds refPeriod. With refEn high, the first refresh request is raised refPeriod+1 cycles after enabling, and then every refPeriod+1 cycles.
- R8: A refresh is served as CLOSE-ALL, tRp NOPs, REFRESH, tRfc NOPs. Then reqReady returns high.
- R9: A refresh never interrupts a burst. A burst with a refresh pending completes in full, and the refresh CLOSE-ALL follows the first idle cycle.
- R10: reqReady is high only when idle with no refresh pending. A request held during a refresh is accepted when the refresh ends, and ACTIVATE follows acceptance by one cycle.
- R11: Several counter expiries while a refresh is pending yield exactly one REFRESH command.
- R12: After reset the pins show NOP, hostBusy and hostDone are low, and reqReady is high.
- R13: During a beat, sdByteEn enables the low min(transfer bytes, port bytes) lanes. Outside beats it is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Request can be accepted |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Starting column |
| reqSize | input | 2 | Transfer size code |
| reqPort | input | 2 | Port width code |
| casLat | input | 2 | Row-to-column delay in cycles |
| tRas | input | TW | Minimum cycles from ACTIVATE to CLOSE-ALL |
| tRp | input | TW | Idle cycles after CLOSE-ALL |
| tRfc | input | TW | Idle cycles after REFRESH |
| refPeriod | input | REF_W | Refresh counter reload value |
| refEn | input | 1 | Refresh counter enable |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdAddr | output | ADDR_W | SDRAM address |
| sdByteEn | output | 4 | Byte lane enables, active high |
| hostBusy | output | 1 | Burst in progress |
| hostDone | output | 1 | One-cycle burst completion pulse |

## Verification
The hardest situation to reach is a counter that expires several times while one refresh is already pending. The count must not pile up. The bench gets there by starting a sixteen-beat burst, then enabling a very short refresh period, so the counter expires repeatedly inside the burst. It disables refresh in the first idle cycle and then counts REFRESH commands. A request held valid across a running refresh is also driven, to check that acceptance waits for the end of the refresh recovery.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  localparam int LANES    = 4;
  localparam int PALL_BIT = 10;
  localparam int BEAT_W   = 4;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100,
    CMD_PALL  = 4'b0010,
    CMD_REF   = 4'b0001
  } sdCmd_e;

  typedef enum logic [1:0] {ADDR_NONE, ADDR_ROW, ADDR_COL, ADDR_PALL} addrSel_e;
  typedef enum logic [1:0] {WAIT_RCD, WAIT_RP, WAIT_RFC} waitSel_e;

  typedef struct packed {
    logic     capture;
    logic     beatStep;
    logic     waitLoad;
    waitSel_e waitSel;
    logic     waitStep;
    logic     finish;
    logic     refClear;
    addrSel_e addrSel;
    logic     beatActive;
  } ctlStrobe_t;

  typedef struct packed {
    logic waitZero;
    logic lastBeat;
    logic rasOkNext;
    logic refPending;
    logic isWrite;
  } dpStatus_t;

endpackage

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int TW     = 4,
  parameter int REF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        reqPort,
  input  logic [1:0]        casLat,
  input  logic [TW-1:0]     tRas,
  input  logic [TW-1:0]     tRp,
  input  logic [TW-1:0]     tRfc,
  input  logic [REF_W-1:0]  refPeriod,
  input  logic              refEn,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [LANES-1:0]  sdByteEn,
  output logic              hostDone,
  output dpStatus_t         st
);

  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic              writeQ;
  logic [BEAT_W-1:0] beatsM1Q, beatsM1Nxt, beatIdx;
  logic [LANES-1:0]  laneQ, laneNxt;
  logic [TW-1:0]     waitCnt, waitLoadVal, rasCnt;
  logic [REF_W-1:0]  refCnt;
  logic              refPendQ, refHit, doneQ;
  logic [2:0]        szLog, ptLog, actLog;

  // Beat count and lane mask from the size and port codes
  always_comb begin
    szLog = (reqSize == 2'd3) ? 3'd4 : {1'b0, reqSize};
    ptLog = (reqPort == 2'd3) ? 3'd2 : {1'b0, reqPort};
    if (szLog > ptLog) begin
      beatsM1Nxt = BEAT_W'((5'd1 << (szLog - ptLog)) - 5'd1);
      actLog     = ptLog;
    end else begin
      beatsM1Nxt = '0;
      actLog     = szLog;
    end
    laneNxt = LANES'((5'd1 << (3'd1 << actLog)) - 5'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ <= '0; colQ <= '0; writeQ <= 1'b0;
      beatsM1Q <= '0; laneQ <= '0;
    end else if (stb.capture) begin
      rowQ <= reqRow; colQ <= reqCol; writeQ <= reqWrite;
      beatsM1Q <= beatsM1Nxt; laneQ <= laneNxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             beatIdx <= '0;
    else if (stb.capture)  beatIdx <= '0;
    else if (stb.beatStep) beatIdx <= beatIdx + 1'b1;
  end

  // Cycles since ACTIVATE, saturating
  always_ff @(posedge clk) begin
    if (!rstN)              rasCnt <= '0;
    else if (stb.capture)   rasCnt <= '0;
    else if (rasCnt != '1)  rasCnt <= rasCnt + 1'b1;
  end

  always_comb begin
    case (stb.waitSel)
      WAIT_RCD: waitLoadVal = TW'(casLat) - TW'(2);
      WAIT_RP:  waitLoadVal = tRp - 1'b1;
      WAIT_RFC: waitLoadVal = tRfc - 1'b1;
      default:  waitLoadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             waitCnt <= '0;
    else if (stb.waitLoad) waitCnt <= waitLoadVal;
    else if (stb.waitStep) waitCnt <= waitCnt - 1'b1;
  end

  // Refresh down-counter and single pending flag
  assign refHit = refEn && (refCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt   <= '0;
      refPendQ <= 1'b0;
    end else begin
      if (!refEn || refHit) refCnt <= refPeriod;
      else                  refCnt <= refCnt - 1'b1;
      if (refHit)            refPendQ <= 1'b1;
      else if (stb.refClear) refPendQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= stb.finish;
  end

  always_comb begin
    case (stb.addrSel)
      ADDR_ROW:  sdAddr = ADDR_W'(rowQ);
      ADDR_COL:  sdAddr = ADDR_W'(colQ + COL_W'(beatIdx));
      ADDR_PALL: sdAddr = ADDR_W'(1) << PALL_BIT;
      default:   sdAddr = '0;
    endcase
  end

  assign sdByteEn     = stb.beatActive ? laneQ : '0;
  assign hostDone     = doneQ;
  assign st.waitZero  = (waitCnt == '0);
  assign st.lastBeat  = (beatIdx == beatsM1Q);
  assign st.rasOkNext = ({1'b0, rasCnt} + 1'b1) >= {1'b0, tRas};
  assign st.refPending = refPendQ;
  assign st.isWrite   = writeQ;

endmodule

// File: rtl/sdram_seq_ctl.sv
module sdram_seq_ctl
  import sdram_seq_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [1:0]    casLat,
  input  logic [TW-1:0] tRp,
  input  logic [TW-1:0] tRfc,
  input  dpStatus_t     st,
  output logic          reqReady,
  output logic          hostBusy,
  output sdCmd_e        cmd,
  output ctlStrobe_t    stb
);

  typedef enum logic [3:0] {
    S_IDLE, S_ACT, S_RCD, S_BEAT, S_RAS, S_PALL, S_RP,
    S_RPALL, S_RWAIT, S_REF, S_RFC
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt         = state;
    stb         = '0;
    stb.waitSel = WAIT_RCD;
    stb.addrSel = ADDR_NONE;
    cmd         = CMD_NOP;
    hostBusy    = 1'b0;
    reqReady    = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = !st.refPending;
        if (st.refPending) nxt = S_RPALL;
        else if (reqValid) begin
          stb.capture = 1'b1;
          nxt = S_ACT;
        end
      end
      S_ACT: begin
        hostBusy = 1'b1;
        cmd = CMD_ACT;
        stb.addrSel = ADDR_ROW;
        if (casLat > 2'd1) begin
          stb.waitLoad = 1'b1;
          stb.waitSel = WAIT_RCD;
          nxt = S_RCD;
        end else nxt = S_BEAT;
      end
      S_RCD: begin
        hostBusy = 1'b1;
        if (st.waitZero) nxt = S_BEAT;
        else stb.waitStep = 1'b1;
      end
      S_BEAT: begin
        hostBusy = 1'b1;
        cmd = st.isWrite ? CMD_WRITE : CMD_READ;
        stb.addrSel = ADDR_COL;
        stb.beatActive = 1'b1;
        stb.beatStep = 1'b1;
        if (st.lastBeat) nxt = st.rasOkNext ? S_PALL : S_RAS;
      end
      S_RAS: begin
        hostBusy = 1'b1;
        if (st.rasOkNext) nxt = S_PALL;
      end
      S_PALL: begin
        hostBusy = 1'b1;
        cmd = CMD_PALL;
        stb.addrSel = ADDR_PALL;
        if (tRp != '0) begin
          stb.waitLoad = 1'b1;
          stb.waitSel = WAIT_RP;
          nxt = S_RP;
        end else begin
          stb.finish = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_RP: begin
        hostBusy = 1'b1;
        if (st.waitZero) begin
          stb.finish = 1'b1;
          nxt = S_IDLE;
        end else stb.waitStep = 1'b1;
      end
      S_RPALL: begin
        cmd = CMD_PALL;
        stb.addrSel = ADDR_PALL;
        if (tRp != '0) begin
          stb.waitLoad = 1'b1;
          stb.waitSel = WAIT_RP;
          nxt = S_RWAIT;
        end else nxt = S_REF;
      end
      S_RWAIT: begin
        if (st.waitZero) nxt = S_REF;
        else stb.waitStep = 1'b1;
      end
      S_REF: begin
        cmd = CMD_REF;
        if (tRfc != '0) begin
          stb.waitLoad = 1'b1;
          stb.waitSel = WAIT_RFC;
          nxt = S_RFC;
        end else begin
          stb.refClear = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_RFC: begin
        if (st.waitZero) begin
          stb.refClear = 1'b1;
          nxt = S_IDLE;
        end else stb.waitStep = 1'b1;
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int TW     = 4,
  parameter int REF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        reqPort,
  input  logic [1:0]        casLat,
  input  logic [TW-1:0]     tRas,
  input  logic [TW-1:0]     tRp,
  input  logic [TW-1:0]     tRfc,
  input  logic [REF_W-1:0]  refPeriod,
  input  logic              refEn,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [3:0]        sdByteEn,
  output logic              hostBusy,
  output logic              hostDone
);

  ctlStrobe_t stb;
  dpStatus_t  st;
  sdCmd_e     cmd;

  sdram_seq_ctl #(.TW(TW)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .casLat(casLat),
    .tRp(tRp), .tRfc(tRfc), .st(st), .reqReady(reqReady),
    .hostBusy(hostBusy), .cmd(cmd), .stb(stb)
  );

  sdram_seq_dp #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .TW(TW), .REF_W(REF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqCol(reqCol), .reqSize(reqSize), .reqPort(reqPort),
    .casLat(casLat), .tRas(tRas), .tRp(tRp), .tRfc(tRfc),
    .refPeriod(refPeriod), .refEn(refEn), .sdAddr(sdAddr),
    .sdByteEn(sdByteEn), .hostDone(hostDone), .st(st)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmd;

endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        casLat,
  input logic              sdCsN,
  input logic              sdRasN,
  input logic              sdCasN,
  input logic              sdWeN,
  input logic [ADDR_W-1:0] sdAddr,
  input logic [3:0]        sdByteEn,
  input logic              hostBusy,
  input logic              hostDone
);

  logic [3:0] pins;
  logic       isBeat;
  assign pins   = {sdCsN, sdRasN, sdCasN, sdWeN};
  assign isBeat = (pins == 4'b0101) || (pins == 4'b0100);

  // R10
  accept_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> pins == 4'b0011);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |-> !hostBusy);

  // R6
  pall_a10_chk: assert property (@(posedge clk) disable iff (!rstN)
    pins == 4'b0010 |-> sdAddr[10]);

  // R13
  lane_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdByteEn != 4'b0000) == isBeat);

  // R9
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    pins == 4'b0001 |-> !hostBusy);

  // R2
  cas_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pins == 4'b0011) && (casLat <= 2'd1) |=> isBeat);

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sdram_burst_seq_tb.sv
`timescale 1ns/1ps
module sdram_burst_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, refEn = 1'b0;
  logic [12:0] reqRow = '0;
  logic [9:0]  reqCol = '0;
  logic [1:0]  reqSize = '0, reqPort = '0, casLat = 2'd1;
  logic [3:0]  tRas = '0, tRp = '0, tRfc = '0;
  logic [15:0] refPeriod = 16'd20;
  logic        reqReady, sdCsN, sdRasN, sdCasN, sdWeN, hostBusy, hostDone;
  logic [12:0] sdAddr;
  logic [3:0]  sdByteEn;
  logic [3:0]  pins;

  int checks = 0, errors = 0;

  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_PALL = 4'b0010, P_REF = 4'b0001;

  typedef struct packed {
    logic       wr;
    logic [1:0] sz;
    logic [1:0] pt;
    logic [1:0] cl;
    logic [3:0] ras;
    logic [3:0] rp;
    logic [4:0] beats;
    logic [4:0] pall;
    logic [3:0] lane;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 2'd3, 2'd2, 2'd2, 4'd3, 4'd2, 5'd4,  5'd6,  4'hF},
    '{1'b1, 2'd3, 2'd1, 2'd1, 4'd2, 4'd0, 5'd8,  5'd9,  4'h3},
    '{1'b0, 2'd0, 2'd2, 2'd3, 4'd7, 4'd1, 5'd1,  5'd7,  4'h1},
    '{1'b1, 2'd2, 2'd0, 2'd2, 4'd5, 4'd3, 5'd4,  5'd6,  4'h1},
    '{1'b1, 2'd3, 2'd0, 2'd1, 4'd4, 4'd1, 5'd16, 5'd17, 4'h1},
    '{1'b0, 2'd1, 2'd2, 2'd1, 4'd6, 4'd0, 5'd1,  5'd6,  4'h3}
  };

  sdram_burst_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol),
    .reqSize(reqSize), .reqPort(reqPort), .casLat(casLat), .tRas(tRas),
    .tRp(tRp), .tRfc(tRfc), .refPeriod(refPeriod), .refEn(refEn),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdAddr(sdAddr), .sdByteEn(sdByteEn), .hostBusy(hostBusy),
    .hostDone(hostDone)
  );

  assign pins = {sdCsN, sdRasN, sdCasN, sdWeN};

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Run one burst; the sample after acceptance is cycle 0 (ACTIVATE)
  task automatic runBurst(input vec_t v, input logic [12:0] row, input logic [9:0] col,
                          output int firstBeat, output int beatCnt, output int pallK,
                          output int idleK, output int seqErr, output int laneErr,
                          output int doneErr);
    firstBeat = -1; beatCnt = 0; pallK = -1; idleK = -1;
    seqErr = 0; laneErr = 0; doneErr = 0;
    while (!reqReady) step();
    reqWrite = v.wr; reqSize = v.sz; reqPort = v.pt; casLat = v.cl;
    tRas = v.ras; tRp = v.rp; reqRow = row; reqCol = col; reqValid = 1'b1;
    step();
    reqValid = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (k == 0) begin
        if (pins != P_ACT || sdAddr != row) seqErr++;
      end else if (!hostBusy) begin
        idleK = k;
        if (!hostDone) doneErr++;
        break;
      end else if (pins == P_RD || pins == P_WR) begin
        if (pins != (v.wr ? P_WR : P_RD)) seqErr++;
        if (pallK >= 0) seqErr++;
        if (firstBeat < 0) firstBeat = k;
        if (sdAddr != 13'(col + 10'(beatCnt))) seqErr++;
        if (sdByteEn != v.lane) laneErr++;
        beatCnt++;
      end else if (pins == P_PALL) begin
        if (pallK >= 0 || sdAddr != 13'h0400) seqErr++;
        pallK = k;
      end else if (pins != P_NOP) seqErr++;
      if (k > 0 && hostDone) doneErr++;
      if (sdByteEn != 4'b0000 && pins != P_RD && pins != P_WR) laneErr++;
      step();
    end
    step();
    if (hostDone) doneErr++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fb, bc, pk, ik, se, le, de, rcd, refK, rdyK, pall2, actK, refCount;
    bit earlyReady, refInBurst;
    repeat (4) step();
    rstN = 1'b1;
    step();
    // R12 reset state
    check(pins == P_NOP, "R12 reset pins", pins, P_NOP);
    check(!hostBusy && !hostDone, "R12 reset busy/done", {hostBusy, hostDone}, 0);
    check(reqReady, "R12 reset ready", reqReady, 1);

    // Table of bursts
    for (int i = 0; i < 6; i++) begin
      runBurst(VEC[i], 13'(100 + i), 10'(8 * i + 4), fb, bc, pk, ik, se, le, de);
      rcd = (VEC[i].cl > 1) ? int'(VEC[i].cl) - 1 : 0;
      check(fb == rcd + 1, "R2 first beat cycle", fb, rcd + 1);
      check(bc == int'(VEC[i].beats), "R3 beat count", bc, VEC[i].beats);
      check(pk == int'(VEC[i].pall), "R4 close-all cycle", pk, VEC[i].pall);
      check(ik == pk + int'(VEC[i].rp) + 1, "R5 busy release cycle", ik, pk + int'(VEC[i].rp) + 1);
      check(de == 0, "R5 done pulse", de, 0);
      check(se == 0, "R1 R6 sequence and address", se, 0);
      check(le == 0, "R13 byte lanes", le, 0);
    end

    // R7 / R8 refresh timing
    tRp = 4'd2; tRfc = 4'd3; refPeriod = 16'd20;
    refEn = 1'b1;
    pk = 0;
    for (int k = 1; k < 100; k++) begin
      step();
      if (pins == P_PALL) begin pk = k; break; end
    end
    check(pk == 22, "R7 first refresh delay", pk, 22);
    refK = -1; rdyK = -1; pall2 = -1;
    for (int k = 1; k < 100; k++) begin
      step();
      if (pins == P_REF && refK < 0) refK = k;
      if (reqReady && rdyK < 0) rdyK = k;
      if (pins == P_PALL) begin pall2 = k; break; end
    end
    check(refK == 3, "R8 refresh after close-all", refK, 3);
    check(rdyK == 7, "R8 ready after refresh", rdyK, 7);
    check(pall2 == 21, "R7 refresh period", pall2, 21);

    // R10 request held during a refresh
    refEn = 1'b0;
    check(!reqReady, "R10 ready low during refresh", reqReady, 0);
    reqWrite = 1'b0; reqSize = 2'd2; reqPort = 2'd2; casLat = 2'd1;
    tRas = 4'd2; reqRow = 13'd7; reqCol = 10'd0; reqValid = 1'b1;
    actK = -1; earlyReady = 1'b0;
    for (int k = 1; k < 40; k++) begin
      step();
      if (reqReady && k < 7) earlyReady = 1'b1;
      if (pins == P_ACT) begin actK = k; break; end
    end
    reqValid = 1'b0;
    check(actK == 8, "R10 activate after refresh", actK, 8);
    check(!earlyReady, "R10 no early ready", earlyReady, 0);
    while (hostBusy) step();

    // R9 / R11 refresh pending through a long burst
    refPeriod = 16'd3; tRp = 4'd1; tRfc = 4'd2;
    while (!reqReady) step();
    reqWrite = 1'b1; reqSize = 2'd3; reqPort = 2'd0; casLat = 2'd1;
    tRas = 4'd4; reqRow = 13'd55; reqCol = 10'd16; reqValid = 1'b1;
    step();
    reqValid = 1'b0;
    refEn = 1'b1;
    bc = 0; refInBurst = 1'b0; pk = -1;
    for (int k = 0; k < 60; k++) begin
      if (!hostBusy) break;
      if (pins == P_WR) bc++;
      if (pins == P_REF) refInBurst = 1'b1;
      if (pins == P_PALL) pk = k;
      step();
    end
    refEn = 1'b0;
    check(bc == 16, "R9 burst beats intact", bc, 16);
    check(pk == 17, "R9 burst close-all cycle", pk, 17);
    check(!refInBurst, "R9 no refresh inside burst", refInBurst, 0);
    check(!reqReady, "R10 ready low with refresh pending", reqReady, 0);
    step();
    check(pins == P_PALL, "R9 refresh close-all after burst", pins, P_PALL);
    refCount = 0;
    for (int k = 0; k < 40; k++) begin
      if (pins == P_REF) refCount++;
      step();
    end
    check(refCount == 1, "R11 single refresh", refCount, 1);
    check(reqReady, "R11 ready after single refresh", reqReady, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule